// File: doc/BRIEF.md
# Locked-Rotor Protection Latch

This block guards a three-phase brushless drive against a stalled rotor. While the motor is commanded to turn, a cycle counter measures the gap since the last Hall transition. If that gap reaches a configured limit, the block latches a fault state that forces the low-side (PWM) gates off. The fault stays set until one of a small set of release events arrives. Thermal shutdown coming and going does not clear it.

Release comes in two kinds. A reset-type release sends the block back through a restart delay before it watches the rotor again: the brake request going high and then low, or the supply undervoltage flag going away. A quick release re-arms the stall watch at once: a change of the direction input, or a zero-duty indication followed by a rising-duty event. The Hall sensor bias can be set either to drop while the fault is latched, which saves power, or to stay on, which keeps the speed-feedback output alive. Both the stall limit and the restart delay are counted in clock cycles.

Top module: `rotor_lock_guard`

## Requirements
- R1: After reset, and after every reset-type release, the block spends exactly RESTART_CYC clock cycles in the restart delay. During the delay `restart_pend` and `lowside_off` are 1 and `lock_fault` is 0. It then enters the watch state, where all three are 0.
- R2: In the watch state, `lock_fault` rises at the clock edge that ends LOCK_CYC consecutive running cycles with no `hall_evt`. A cycle is running when `brake`, `duty_zero`, `uv_flag` and `ot_flag` are all 0. Any cycle with `hall_evt` high restarts the count from zero.
- R3: A cycle that is not running clears the stall count. Raising `brake` or `ot_flag` for any length of time in the watch state therefore never sets the fault, and a full LOCK_CYC running cycles are needed after it drops.
- R4: While `lock_fault` is 1, `lowside_off` is 1. Hall events and any rise or fall of `ot_flag` leave the fault set.
- R5: A rising then falling `brake` while the fault is set clears the fault at the falling edge and starts the restart delay.
- R6: Any change of `dir` while the fault is set clears the fault in the same cycle and goes straight to the watch state, with no restart delay.
- R7: A rising `duty_zero` while the fault is set, followed later by a `duty_up` pulse, clears the fault straight into the watch state. A `duty_up` pulse with no prior zero-duty rise during the fault has no effect.
- R8: The fault holds while `uv_flag` is 1, and the falling edge of `uv_flag` clears it into the restart delay. In the watch state, `uv_flag` high sends the block into the restart delay, and the delay count starts only once `uv_flag` is 0.
- R9: `hall_bias_en` is 0 only when `lock_fault` is 1 and `bias_keep` is 0 (power-saving mode). With `bias_keep` = 1 (feedback mode), bias stays on during the fault.
- R10: Releases act on input edges only. A `dir` level that was already present when the fault latched does not release it.
- R11: When a reset-type release and a quick release occur in the same cycle, the reset-type release wins and the restart delay runs.
- R12: `restart_pend` is 1 only in the restart delay, never together with `lock_fault`. `lowside_off` is 1 exactly in the restart delay and in the fault state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_evt | input | 1 | One-cycle pulse per Hall sensor transition |
| brake | input | 1 | 1 = brake requested, 0 = run requested |
| dir | input | 1 | Rotation direction request |
| duty_zero | input | 1 | Speed command judged to be zero duty |
| duty_up | input | 1 | One-cycle pulse when commanded duty rises |
| uv_flag | input | 1 | Supply undervoltage present |
| ot_flag | input | 1 | Thermal shutdown active |
| bias_keep | input | 1 | 1 = Hall bias stays on during fault, 0 = power-saving |
| lock_fault | output | 1 | Locked-rotor fault latched |
| lowside_off | output | 1 | Forces all low-side gates off |
| hall_bias_en | output | 1 | Hall sensor bias enable |
| restart_pend | output | 1 | Restart delay in progress |

## Verification
The bench builds the block with LOCK_CYC = 40 and RESTART_CYC = 8 instead of seconds and milliseconds. At these values every trip, release and restart can be counted edge by edge inside a few hundred cycles. The bench checks the fault one cycle before and one cycle after the exact trip edge, and checks the last delay cycle against the first watch cycle. These small values also let one run chain every release path, both bias modes, the same-cycle priority case and the pause by brake and by thermal shutdown.

// File: rtl/rlg_pkg.sv
package rlg_pkg;

  typedef enum logic [1:0] {
    G_DELAY = 2'd0,
    G_WATCH = 2'd1,
    G_LOCK  = 2'd2
  } guard_st_e;

  // Indices into the watched control vector for edge detection
  localparam int unsigned IDX_BRK = 0;
  localparam int unsigned IDX_DIR = 1;
  localparam int unsigned IDX_DZ  = 2;
  localparam int unsigned IDX_UV  = 3;
  localparam int unsigned N_WATCH = 4;

  // A cycle counts toward a stall only when the motor is meant to turn
  function automatic logic motor_running(input logic brk, input logic dz,
                                         input logic uv, input logic ot);
    return !brk && !dz && !uv && !ot;
  endfunction

  function automatic logic bias_allowed(input logic locked, input logic keep);
    return !locked || keep;
  endfunction

  function automatic guard_st_e next_state(input guard_st_e cur,
                                           input logic dly_done,
                                           input logic uv,
                                           input logic trip,
                                           input logic rel_rst,
                                           input logic rel_q);
    guard_st_e n;
    n = cur;
    case (cur)
      G_DELAY: if (dly_done) n = G_WATCH;
      G_WATCH: begin
        if (uv)        n = G_DELAY;
        else if (trip) n = G_LOCK;
      end
      G_LOCK: begin
        if (rel_rst)    n = G_DELAY;
        else if (rel_q) n = G_WATCH;
      end
      default: n = G_DELAY;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rlg_edge_bank.sv
module rlg_edge_bank #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] chg
);

  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= sig[g];
    end
    assign chg[g] = sig[g] ^ prev_q[g];
  end

endmodule

// File: rtl/rlg_span_timer.sv
module rlg_span_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic hit
);

  localparam int unsigned CW   = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign hit = !clear && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clear || hit) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/rlg_release_arb.sv
module rlg_release_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic locked,
  input  logic brk_fall,
  input  logic uv_fall,
  input  logic dir_chg,
  input  logic dz_rise,
  input  logic duty_up,
  output logic rel_reset,
  output logic rel_quick
);

  logic zero_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       zero_seen_q <= 1'b0;
    else if (!locked) zero_seen_q <= 1'b0;
    else if (dz_rise) zero_seen_q <= 1'b1;
  end

  assign rel_reset = locked && (brk_fall || uv_fall);
  assign rel_quick = locked && (dir_chg || (zero_seen_q && duty_up));

endmodule

// File: rtl/rotor_lock_guard.sv
module rotor_lock_guard
  import rlg_pkg::*;
#(
  parameter int unsigned LOCK_CYC    = 400_000_000,
  parameter int unsigned RESTART_CYC = 200_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hall_evt,
  input  logic brake,
  input  logic dir,
  input  logic duty_zero,
  input  logic duty_up,
  input  logic uv_flag,
  input  logic ot_flag,
  input  logic bias_keep,
  output logic lock_fault,
  output logic lowside_off,
  output logic hall_bias_en,
  output logic restart_pend
);

  guard_st_e st_q, st_d;

  logic [N_WATCH-1:0] watch_vec, watch_chg;
  logic brk_fall, uv_fall, dir_chg, dz_rise;
  logic run_ok, stall_clr, stall_trip, dly_clr, dly_done;
  logic rel_reset, rel_quick;

  always_comb begin
    watch_vec          = '0;
    watch_vec[IDX_BRK] = brake;
    watch_vec[IDX_DIR] = dir;
    watch_vec[IDX_DZ]  = duty_zero;
    watch_vec[IDX_UV]  = uv_flag;
  end

  rlg_edge_bank #(.W(N_WATCH)) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .sig   (watch_vec),
    .chg   (watch_chg)
  );

  assign brk_fall = watch_chg[IDX_BRK] && !brake;
  assign uv_fall  = watch_chg[IDX_UV]  && !uv_flag;
  assign dz_rise  = watch_chg[IDX_DZ]  && duty_zero;
  assign dir_chg  = watch_chg[IDX_DIR];

  assign run_ok    = motor_running(brake, duty_zero, uv_flag, ot_flag);
  assign stall_clr = (st_q != G_WATCH) || !run_ok || hall_evt;
  assign dly_clr   = (st_q != G_DELAY) || uv_flag;

  rlg_span_timer #(.LIMIT(LOCK_CYC)) u_stall (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (stall_clr),
    .hit   (stall_trip)
  );

  rlg_span_timer #(.LIMIT(RESTART_CYC)) u_restart (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (dly_clr),
    .hit   (dly_done)
  );

  rlg_release_arb u_rel (
    .clk       (clk),
    .rst_n     (rst_n),
    .locked    (st_q == G_LOCK),
    .brk_fall  (brk_fall),
    .uv_fall   (uv_fall),
    .dir_chg   (dir_chg),
    .dz_rise   (dz_rise),
    .duty_up   (duty_up),
    .rel_reset (rel_reset),
    .rel_quick (rel_quick)
  );

  assign st_d = next_state(st_q, dly_done, uv_flag, stall_trip, rel_reset, rel_quick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= G_DELAY;
    else        st_q <= st_d;
  end

  assign lock_fault   = (st_q == G_LOCK);
  assign restart_pend = (st_q == G_DELAY);
  assign lowside_off  = (st_q != G_WATCH);
  assign hall_bias_en = bias_allowed(st_q == G_LOCK, bias_keep);

endmodule

// File: rtl/rotor_lock_guard_chk.sv
module rotor_lock_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic lock_fault,
  input logic lowside_off,
  input logic restart_pend,
  input logic hall_bias_en,
  input logic uv_flag,
  input logic run_ok,
  input logic rel_reset,
  input logic rel_quick
);

  // R4
  lock_lowside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_fault |-> lowside_off);

  // R12
  pend_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pend |-> (lowside_off && !lock_fault));

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_fault && !rel_reset && !rel_quick) |=> lock_fault);

  // R2
  trip_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_fault) |-> ($past(run_ok) && !$past(restart_pend)));

  // R11
  rel_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_fault && rel_reset) |=> restart_pend);

  // R6
  rel_quick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_fault && rel_quick && !rel_reset) |=> (!lock_fault && !restart_pend));

  // R8
  uv_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_flag && !lock_fault) |=> restart_pend);

  // R9
  bias_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_fault |-> hall_bias_en);

endmodule

bind rotor_lock_guard rotor_lock_guard_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lock_fault   (lock_fault),
  .lowside_off  (lowside_off),
  .restart_pend (restart_pend),
  .hall_bias_en (hall_bias_en),
  .uv_flag      (uv_flag),
  .run_ok       (run_ok),
  .rel_reset    (rel_reset),
  .rel_quick    (rel_quick)
);

// File: tb/rotor_lock_guard_bench.sv
`timescale 1ns/100ps
module rotor_lock_guard_bench;

  localparam int unsigned LOCK_T  = 40;
  localparam int unsigned DELAY_T = 8;

  // expected output code {lock_fault, lowside_off, hall_bias_en, restart_pend}
  localparam logic [3:0] E_DLY  = 4'b0111;
  localparam logic [3:0] E_RUN  = 4'b0010;
  localparam logic [3:0] E_LK0  = 4'b1100;
  localparam logic [3:0] E_LK1  = 4'b1110;

  // row: [27:24] req, [23:16] edges, [15:8] inputs, [3:0] expected
  // inputs [15:8] = {brk, dir, dz, dup, uv, ot, keep, hall}
  function automatic logic [27:0] mk(input int req, input int n, input logic [7:0] ins,
                                     input logic [3:0] ex);
    return {4'(req), 8'(n), ins, 4'b0, ex};
  endfunction

  localparam int NV = 45;
  localparam logic [27:0] VEC [NV] = '{
    mk(1,  7,  8'b0000_0000, E_DLY),  // R1 delay after reset
    mk(1,  1,  8'b0000_0000, E_RUN),  // R1 watch entered
    mk(2,  5,  8'b0000_0001, E_RUN),  // R2 hall activity
    mk(2,  39, 8'b0000_0000, E_RUN),  // R2 one short of limit
    mk(2,  1,  8'b0000_0000, E_LK0),  // R2 trip, R9 bias off
    mk(9,  1,  8'b0000_0010, E_LK1),  // R9 feedback mode keeps bias
    mk(4,  3,  8'b0000_0110, E_LK1),  // R4 thermal rises
    mk(4,  3,  8'b0000_0011, E_LK1),  // R4 thermal clears, hall seen
    mk(6,  1,  8'b0100_0010, E_RUN),  // R6 direction toggle
    mk(2,  39, 8'b0100_0010, E_RUN),
    mk(2,  1,  8'b0100_0010, E_LK1),
    mk(10, 5,  8'b0100_0010, E_LK1),  // R10 dir level held
    mk(7,  2,  8'b0110_0010, E_LK1),  // R7 zero duty rises
    mk(7,  1,  8'b0101_0010, E_RUN),  // R7 duty rises
    mk(2,  39, 8'b0100_0010, E_RUN),
    mk(2,  1,  8'b0100_0010, E_LK1),
    mk(7,  1,  8'b0101_0010, E_LK1),  // R7 duty rise alone
    mk(7,  1,  8'b0100_0010, E_LK1),
    mk(9,  3,  8'b1100_0000, E_LK0),  // R9 power saving, brake high
    mk(5,  1,  8'b0100_0000, E_DLY),  // R5 brake low
    mk(12, 7,  8'b0100_0000, E_DLY),  // R12 delay encoding
    mk(1,  1,  8'b0100_0000, E_RUN),
    mk(2,  39, 8'b0100_0000, E_RUN),
    mk(2,  1,  8'b0100_0000, E_LK0),
    mk(8,  4,  8'b0100_1000, E_LK0),  // R8 fault held under uv
    mk(8,  1,  8'b0100_0000, E_DLY),  // R8 uv recovery
    mk(8,  7,  8'b0100_0000, E_DLY),
    mk(8,  1,  8'b0100_0000, E_RUN),
    mk(3,  10, 8'b0100_0000, E_RUN),
    mk(8,  2,  8'b0100_1000, E_DLY),  // R8 uv in watch
    mk(8,  7,  8'b0100_0000, E_DLY),
    mk(8,  1,  8'b0100_0000, E_RUN),
    mk(3,  30, 8'b0100_0000, E_RUN),
    mk(3,  50, 8'b1100_0000, E_RUN),  // R3 brake pause
    mk(3,  39, 8'b0100_0000, E_RUN),
    mk(3,  1,  8'b0100_0000, E_LK0),
    mk(6,  1,  8'b0000_0000, E_RUN),  // R6 toggle back
    mk(2,  39, 8'b0000_0000, E_RUN),
    mk(2,  1,  8'b0000_0000, E_LK0),
    mk(11, 2,  8'b1000_0000, E_LK0),
    mk(11, 1,  8'b0100_0000, E_DLY),  // R11 brake fall with dir change
    mk(11, 8,  8'b0100_0000, E_RUN),
    mk(3,  30, 8'b0100_0100, E_RUN),  // R3 thermal pause
    mk(3,  39, 8'b0100_0000, E_RUN),
    mk(3,  1,  8'b0100_0000, E_LK0)
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hall_evt = 0, brake = 0, dir = 0, duty_zero = 0, duty_up = 0;
  logic uv_flag = 0, ot_flag = 0, bias_keep = 0;
  logic lock_fault, lowside_off, hall_bias_en, restart_pend;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rotor_lock_guard #(.LOCK_CYC(LOCK_T), .RESTART_CYC(DELAY_T)) u_rotor_lock_guard (
    .clk(clk), .rst_n(rst_n), .hall_evt(hall_evt), .brake(brake), .dir(dir),
    .duty_zero(duty_zero), .duty_up(duty_up), .uv_flag(uv_flag), .ot_flag(ot_flag),
    .bias_keep(bias_keep), .lock_fault(lock_fault), .lowside_off(lowside_off),
    .hall_bias_en(hall_bias_en), .restart_pend(restart_pend)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input int req, input int tag, input logic [3:0] ex);
    logic [3:0] got;
    got = {lock_fault, lowside_off, hall_bias_en, restart_pend};
    n_chk++;
    if (got !== ex) begin
      n_bad++;
      $display("FAIL R%0d step %0d: got %b expected %b", req, tag, got, ex);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    tick(3);
    check(1, -1, E_DLY);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [27:0] r;
      r = VEC[i];
      {brake, dir, duty_zero, duty_up, uv_flag, ot_flag, bias_keep, hall_evt} = r[15:8];
      tick(int'(r[23:16]));
      check(int'(r[27:24]), i, r[3:0]);
    end

    // R6 release to watch, then R2 periodic hall keeps fault off
    {brake, duty_up, uv_flag, ot_flag, hall_evt} = '0;
    dir = 1'b0;
    tick(1);
    check(6, 100, E_RUN);
    for (int k = 0; k < 8; k++) begin
      tick(LOCK_T - 2);
      hall_evt = 1'b1;
      tick(1);
      hall_evt = 1'b0;
      check(2, 200 + k, E_RUN);
    end

    // R1 reset in the middle of operation
    tick(LOCK_T + 2);
    check(2, 300, E_LK0);
    rst_n = 1'b0;
    tick(1);
    check(1, 301, E_DLY);
    rst_n = 1'b1;
    tick(DELAY_T);
    check(1, 302, E_RUN);

    finish_run();
  end

endmodule